// File: doc/BRIEF.md
# Cell Header Error Control Generator and Checker

This block protects the five-octet header of a fixed-length cell. On the transmit side it takes the four leading header octets and computes the fifth octet, the header error control (HEC) code. On the receive side it takes all five octets and recomputes the syndrome. A header with a zero syndrome is marked valid. A header with a single-bit error is repaired and marked corrected. Any other header is marked uncorrectable and passed on unchanged.

Static configuration inputs set three options. The first chooses the coverage: all four leading octets for standard cell headers, or only octets two to four for the alternative header layout used by SMDS/802.6. The second enables the coset pattern. The third is a flag for a 4B/5B transceiver link, which always needs the coset. Each direction has its own strobe. The results are registered and appear one clock after the strobe.

Top module: `hec_engine`

## Requirements
- R1: With `cfg_sub_cov`=0 and no coset, `tx_hec` is the CRC-8 remainder of `tx_hdr` (octet one in bits 31:24, first bit in is bit 31), using generator x^8+x^2+x+1 (0x07) and a zero start value. For example, header 0x00000001 gives 0x07.
- R2: With `cfg_sub_cov`=1, octet one (`tx_hdr[31:24]`, `rx_hdr[39:32]`) is excluded. It has no effect on `tx_hec`, on the receive status, or on the receive output, which passes it through unchanged.
- R3: With `cfg_coset_en`=1, the transmitted HEC is the remainder XOR 0x55. For example, header 0x00000001 gives 0x52.
- R4: With the coset active, the receive check XORs 0x55 into the syndrome before detection. A header whose fifth octet (`rx_hdr[7:0]`) was generated with the coset checks as valid.
- R5: `cfg_taxi`=1 forces the coset on in both directions, whatever the value of `cfg_coset_en`.
- R6: A zero syndrome sets `rx_ok` and clears `rx_fixed` and `rx_bad`. In that case `rx_hdr_o` equals `rx_hdr`.
- R7: A nonzero syndrome that matches a single covered bit position sets `rx_fixed`. `rx_hdr_o` is then `rx_hdr` with that one bit inverted.
- R8: Any other nonzero syndrome sets `rx_bad`. `rx_hdr_o` then equals `rx_hdr`.
- R9: `tx_done` and `rx_done` go high for exactly the one clock after `tx_vld` or `rx_vld`. Without a strobe, `tx_hec`, `rx_hdr_o` and the status flags hold their values.
- R10: During reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sub_cov | input | 1 | 1: coverage is octets two to four only |
| cfg_coset_en | input | 1 | Apply the 0x55 coset |
| cfg_taxi | input | 1 | 4B/5B link mode; forces the coset on |
| tx_vld | input | 1 | Transmit header strobe |
| tx_hdr | input | 32 | Four leading header octets, octet one in the top byte |
| tx_done | output | 1 | Transmit result valid |
| tx_hec | output | 8 | Generated HEC octet |
| rx_vld | input | 1 | Receive header strobe |
| rx_hdr | input | 40 | Five received octets, HEC in the low byte |
| rx_done | output | 1 | Receive result valid |
| rx_hdr_o | output | 40 | Header after correction |
| rx_ok | output | 1 | Header valid |
| rx_fixed | output | 1 | Single-bit error corrected |
| rx_bad | output | 1 | Uncorrectable header |

## Verification
The assertions check the following on every cycle:
- the one-clock strobe-to-done timing, and that the results hold between strobes;
- that at most one status flag is set;
- that valid and uncorrectable headers leave the checker unaltered;
- that a corrected header differs from its input in exactly one bit, and never in octet one when the reduced coverage is selected.

Only the bench's scenarios can show that the code values are right:
- the actual CRC remainder;
- the coset offset;
- the forcing of the coset by the link flag;
- that every one of the covered bit positions is located correctly, and that multi-bit errors are sorted into the right class.

// File: rtl/hec_pkg.sv
package hec_pkg;

  localparam int unsigned HEC_W = 8;
  localparam logic [HEC_W-1:0] HEC_POLY  = 8'h07;  // x^8 + x^2 + x + 1
  localparam logic [HEC_W-1:0] HEC_COSET = 8'h55;  // x^6 + x^4 + x^2 + 1

  typedef enum logic [1:0] {
    HDR_OK    = 2'd0,
    HDR_FIXED = 2'd1,
    HDR_BAD   = 2'd2
  } hdr_stat_e;

  // x^n mod generator: syndrome signature of a single error at bit n.
  function automatic logic [HEC_W-1:0] hec_xpow(input int unsigned n);
    logic [HEC_W-1:0] r;
    r = {{(HEC_W-1){1'b0}}, 1'b1};
    for (int unsigned k = 0; k < n; k++) begin
      r = {r[HEC_W-2:0], 1'b0} ^ (r[HEC_W-1] ? HEC_POLY : {HEC_W{1'b0}});
    end
    return r;
  endfunction

endpackage

// File: rtl/hec_crc.sv
module hec_crc #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0]               data,
  output logic [hec_pkg::HEC_W-1:0]   crc
);
  localparam int unsigned CW = hec_pkg::HEC_W;

  always_comb begin
    logic [CW-1:0] r;
    logic          fb;
    r = '0;
    for (int b = DW - 1; b >= 0; b--) begin
      fb = r[CW-1] ^ data[b];
      r  = {r[CW-2:0], 1'b0} ^ (fb ? hec_pkg::HEC_POLY : {CW{1'b0}});
    end
    crc = r;
  end

endmodule

// File: rtl/hec_err_locate.sv
module hec_err_locate #(
  parameter int unsigned CELL_W = 40
) (
  input  logic [hec_pkg::HEC_W-1:0] syn,
  input  logic [CELL_W-1:0]         excl,
  output logic [CELL_W-1:0]         flip
);
  for (genvar i = 0; i < CELL_W; i++) begin : g_pos
    localparam logic [hec_pkg::HEC_W-1:0] SIG = hec_pkg::hec_xpow(i);
    assign flip[i] = (syn == SIG) && !excl[i];
  end
endmodule

// File: rtl/hec_engine.sv
module hec_engine #(
  parameter int unsigned OCT_W   = 8,
  parameter int unsigned HDR_OCT = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_sub_cov,
  input  logic                                 cfg_coset_en,
  input  logic                                 cfg_taxi,
  input  logic                                 tx_vld,
  input  logic [OCT_W*HDR_OCT-1:0]             tx_hdr,
  output logic                                 tx_done,
  output logic [hec_pkg::HEC_W-1:0]            tx_hec,
  input  logic                                 rx_vld,
  input  logic [OCT_W*HDR_OCT+hec_pkg::HEC_W-1:0] rx_hdr,
  output logic                                 rx_done,
  output logic [OCT_W*HDR_OCT+hec_pkg::HEC_W-1:0] rx_hdr_o,
  output logic                                 rx_ok,
  output logic                                 rx_fixed,
  output logic                                 rx_bad
);
  import hec_pkg::*;

  localparam int unsigned HDR_W  = OCT_W * HDR_OCT;
  localparam int unsigned CELL_W = HDR_W + HEC_W;
  localparam int unsigned TAIL_W = HDR_W - OCT_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // Configuration decode.
  logic             coset_on;
  logic [HEC_W-1:0] coset_pat;
  logic [OCT_W-1:0] lead_keep;
  logic [CELL_W-1:0] excl;

  assign coset_on  = cfg_coset_en | cfg_taxi;
  assign coset_pat = coset_on ? HEC_COSET : '0;
  assign lead_keep = {OCT_W{~cfg_sub_cov}};
  assign excl      = cfg_sub_cov ? {{OCT_W{1'b1}}, {(CELL_W-OCT_W){1'b0}}} : '0;

  // With a zero start value, a zeroed leading octet is equivalent to skipping it.
  logic [HDR_W-1:0] tx_cov, rx_cov;
  assign tx_cov = {tx_hdr[HDR_W-1 -: OCT_W] & lead_keep, tx_hdr[TAIL_W-1:0]};
  assign rx_cov = {rx_hdr[CELL_W-1 -: OCT_W] & lead_keep, rx_hdr[HEC_W +: TAIL_W]};

  logic [HEC_W-1:0] tx_crc, rx_crc, syn;

  hec_crc #(.DW(HDR_W)) u_tx_crc (.data(tx_cov), .crc(tx_crc));
  hec_crc #(.DW(HDR_W)) u_rx_crc (.data(rx_cov), .crc(rx_crc));

  assign syn = rx_crc ^ rx_hdr[HEC_W-1:0] ^ coset_pat;

  logic [CELL_W-1:0] flip;
  hec_err_locate #(.CELL_W(CELL_W)) u_loc (.syn(syn), .excl(excl), .flip(flip));

  // Next-state logic.
  logic [HEC_W-1:0]  tx_hec_d;
  logic [CELL_W-1:0] rx_hdr_d;
  hdr_stat_e         stat_d;

  always_comb begin
    tx_hec_d = tx_crc ^ coset_pat;
    if (syn == '0) begin
      stat_d   = HDR_OK;
      rx_hdr_d = rx_hdr;
    end else if (|flip) begin
      stat_d   = HDR_FIXED;
      rx_hdr_d = rx_hdr ^ flip;
    end else begin
      stat_d   = HDR_BAD;
      rx_hdr_d = rx_hdr;
    end
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tx_done  <= 1'b0;
      tx_hec   <= '0;
      rx_done  <= 1'b0;
      rx_hdr_o <= '0;
      rx_ok    <= 1'b0;
      rx_fixed <= 1'b0;
      rx_bad   <= 1'b0;
    end else begin
      tx_done <= tx_vld;
      rx_done <= rx_vld;
      if (tx_vld) begin
        tx_hec <= tx_hec_d;
      end
      if (rx_vld) begin
        rx_hdr_o <= rx_hdr_d;
        rx_ok    <= (stat_d == HDR_OK);
        rx_fixed <= (stat_d == HDR_FIXED);
        rx_bad   <= (stat_d == HDR_BAD);
      end
    end
  end

endmodule

// File: rtl/hec_engine_chk.sv
module hec_engine_chk #(
  parameter int unsigned CELL_W = 40,
  parameter int unsigned OCT_W  = 8
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              cfg_sub_cov,
  input logic              tx_vld,
  input logic              tx_done,
  input logic [7:0]        tx_hec,
  input logic              rx_vld,
  input logic [CELL_W-1:0] rx_hdr,
  input logic              rx_done,
  input logic [CELL_W-1:0] rx_hdr_o,
  input logic              rx_ok,
  input logic              rx_fixed,
  input logic              rx_bad
);

  assert_tx_done_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    tx_vld |=> tx_done);
  assert_tx_quiet_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    !tx_vld |=> (!tx_done && $stable(tx_hec)));
  assert_rx_done_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    rx_vld |=> rx_done);
  assert_rx_quiet_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    !rx_vld |=> (!rx_done && $stable(rx_hdr_o) && $stable({rx_ok, rx_fixed, rx_bad})));
  assert_one_status_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0({rx_ok, rx_fixed, rx_bad}));
  assert_ok_passthru_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    rx_vld |=> (!rx_ok || rx_hdr_o == $past(rx_hdr)));
  assert_fix_onebit_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    rx_vld |=> (!rx_fixed || $countones(rx_hdr_o ^ $past(rx_hdr)) == 1));
  assert_bad_passthru_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    rx_vld |=> (!rx_bad || rx_hdr_o == $past(rx_hdr)));
  assert_lead_kept_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (rx_vld && cfg_sub_cov) |=>
      (rx_hdr_o[CELL_W-1 -: OCT_W] == $past(rx_hdr[CELL_W-1 -: OCT_W])));

endmodule

bind hec_engine hec_engine_chk i_hec_engine_chk (
  .clk(clk), .rst_ok(rst_sync_n), .cfg_sub_cov(cfg_sub_cov),
  .tx_vld(tx_vld), .tx_done(tx_done), .tx_hec(tx_hec),
  .rx_vld(rx_vld), .rx_hdr(rx_hdr), .rx_done(rx_done), .rx_hdr_o(rx_hdr_o),
  .rx_ok(rx_ok), .rx_fixed(rx_fixed), .rx_bad(rx_bad)
);

// File: tb/test_hec_engine.sv
`timescale 1ns/1ps
module test_hec_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_sub_cov = 1'b0, cfg_coset_en = 1'b0, cfg_taxi = 1'b0;
  logic        tx_vld = 1'b0;
  logic [31:0] tx_hdr = '0;
  logic        tx_done;
  logic [7:0]  tx_hec;
  logic        rx_vld = 1'b0;
  logic [39:0] rx_hdr = '0;
  logic        rx_done;
  logic [39:0] rx_hdr_o;
  logic        rx_ok, rx_fixed, rx_bad;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  hec_engine i_hec_engine (
    .clk(clk), .rst_n(rst_n), .cfg_sub_cov(cfg_sub_cov), .cfg_coset_en(cfg_coset_en),
    .cfg_taxi(cfg_taxi), .tx_vld(tx_vld), .tx_hdr(tx_hdr), .tx_done(tx_done),
    .tx_hec(tx_hec), .rx_vld(rx_vld), .rx_hdr(rx_hdr), .rx_done(rx_done),
    .rx_hdr_o(rx_hdr_o), .rx_ok(rx_ok), .rx_fixed(rx_fixed), .rx_bad(rx_bad)
  );

  // Reference model: bit-serial division, optionally skipping the lead octet.
  function automatic logic [7:0] m_crc(input logic [31:0] d, input bit sub);
    logic [7:0] r = 8'h00;
    for (int b = 31; b >= 0; b--) begin
      if (!(sub && b >= 24)) begin
        if (r[7] ^ d[b]) r = {r[6:0], 1'b0} ^ 8'h07;
        else             r = {r[6:0], 1'b0};
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] m_hec(input logic [31:0] d, input bit sub, input bit cos);
    return m_crc(d, sub) ^ (cos ? 8'h55 : 8'h00);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input bit sub, input bit cos, input bit taxi);
    cfg_sub_cov = sub; cfg_coset_en = cos; cfg_taxi = taxi;
  endtask

  // Drive one transmit strobe and check result and timing.
  task automatic tx_apply(input logic [31:0] h, input logic [7:0] exp, input string req);
    @(negedge clk);
    tx_hdr = h; tx_vld = 1'b1;
    @(negedge clk);
    tx_vld = 1'b0;
    check(req, "tx_hec", {32'h0, tx_hec}, {32'h0, exp});
    check("R9", "tx_done pulse", {39'h0, tx_done}, 40'h1);
    tx_hdr = ~h;
    @(negedge clk);
    check("R9", "tx_done low", {39'h0, tx_done}, 40'h0);
    check("R9", "tx_hec hold", {32'h0, tx_hec}, {32'h0, exp});
  endtask

  // Drive one receive strobe; expected outcome derived by trial correction.
  task automatic rx_apply(input logic [39:0] h, input string req);
    bit sub, cos;
    logic [7:0]  s;
    logic [39:0] exp_hdr;
    logic [2:0]  exp_st;
    sub = cfg_sub_cov; cos = cfg_coset_en | cfg_taxi;
    s = m_hec(h[39:8], sub, cos) ^ h[7:0];
    exp_hdr = h;
    if (s == 8'h00) exp_st = 3'b100;
    else begin
      exp_st = 3'b001;
      for (int i = 0; i < 40; i++) begin
        logic [39:0] t;
        if (!(sub && i >= 32)) begin
          t = h ^ (40'h1 << i);
          if ((m_hec(t[39:8], sub, cos) ^ t[7:0]) == 8'h00 && exp_st == 3'b001) begin
            exp_st = 3'b010; exp_hdr = t;
          end
        end
      end
    end
    @(negedge clk);
    rx_hdr = h; rx_vld = 1'b1;
    @(negedge clk);
    rx_vld = 1'b0;
    check(req, "rx status {ok,fixed,bad}", {37'h0, rx_ok, rx_fixed, rx_bad}, {37'h0, exp_st});
    check(req, "rx_hdr_o", rx_hdr_o, exp_hdr);
    check("R9", "rx_done pulse", {39'h0, rx_done}, 40'h1);
  endtask

  task automatic t_reset;
    check("R10", "reset outputs",
          {tx_done, tx_hec, rx_done, rx_ok, rx_fixed, rx_bad, 29'h0}, 40'h0);
    check("R10", "reset rx_hdr_o", rx_hdr_o, 40'h0);
  endtask

  task automatic t_tx_plain;
    set_cfg(0, 0, 0);
    tx_apply(32'h00000001, 8'h07, "R1");
    tx_apply(32'h00000000, 8'h00, "R1");
    tx_apply(32'hDEADBEEF, m_hec(32'hDEADBEEF, 0, 0), "R1");
    tx_apply(32'h12345678, m_hec(32'h12345678, 0, 0), "R1");
    tx_apply(32'hFFFFFFFF, m_hec(32'hFFFFFFFF, 0, 0), "R1");
  endtask

  task automatic t_tx_coset;
    set_cfg(0, 1, 0);
    tx_apply(32'h00000001, 8'h52, "R3");
    tx_apply(32'h00000000, 8'h55, "R3");
    tx_apply(32'hA5C3F00F, m_hec(32'hA5C3F00F, 0, 1), "R3");
  endtask

  task automatic t_taxi;
    set_cfg(0, 0, 1);
    tx_apply(32'h00000001, 8'h52, "R5");
    rx_apply({32'h00000001, 8'h52}, "R5");
    check("R5", "taxi valid", {39'h0, rx_ok}, 40'h1);
  endtask

  task automatic t_sub_cov;
    set_cfg(1, 0, 0);
    tx_apply(32'h00ABCDEF, m_hec(32'h00ABCDEF, 1, 0), "R2");
    tx_apply(32'h77ABCDEF, m_hec(32'h00ABCDEF, 1, 0), "R2");
    rx_apply({32'h99ABCDEF, m_hec(32'h00ABCDEF, 1, 0)}, "R2");
    check("R2", "lead octet ignored -> ok", {39'h0, rx_ok}, 40'h1);
    rx_apply({32'h99ABCDEF, m_hec(32'h00ABCDEF, 1, 0)} ^ 40'h1_0000_0000, "R2");
    for (int i = 0; i < 32; i++)
      rx_apply({32'h5A123456, m_hec(32'h5A123456, 1, 0)} ^ (40'h1 << i), "R2");
  endtask

  task automatic t_rx_valid;
    set_cfg(0, 1, 0);
    rx_apply({32'h00000001, 8'h52}, "R4");
    check("R4", "coset header ok", {39'h0, rx_ok}, 40'h1);
    set_cfg(0, 0, 0);
    rx_apply({32'h0F0F1234, m_hec(32'h0F0F1234, 0, 0)}, "R6");
    check("R6", "plain header ok", {39'h0, rx_ok}, 40'h1);
  endtask

  task automatic t_rx_single;
    logic [39:0] base;
    set_cfg(0, 1, 0);
    base = {32'hC0FFEE11, m_hec(32'hC0FFEE11, 0, 1)};
    for (int i = 0; i < 40; i++) begin
      rx_apply(base ^ (40'h1 << i), "R7");
      check("R7", "corrected to original", rx_hdr_o, base);
    end
  endtask

  task automatic t_rx_multi;
    logic [39:0] base;
    set_cfg(0, 0, 0);
    base = {32'h31415926, m_hec(32'h31415926, 0, 0)};
    rx_apply(base ^ 40'h3, "R8");
    check("R8", "adjacent double error bad", {39'h0, rx_bad}, 40'h1);
    for (int i = 0; i < 16; i++)
      rx_apply(base ^ (40'h1 << i) ^ (40'h1 << (i + 17)), "R8");
    rx_apply(base ^ 40'hFF_0000_0000, "R8");
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_tx_plain();
    t_tx_coset();
    t_taxi();
    t_sub_cov();
    t_rx_valid();
    t_rx_single();
    t_rx_multi();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule